// File: doc/BRIEF.md
# Serial EEPROM Block Transfer Sequencer

This engine runs block reads and block writes against a serial EEPROM with a 16-bit address space. It sits above a byte-level SPI master. The engine drives a chip-select level and hands the master one byte at a time through a request/acknowledge handshake. The master returns the byte it shifted in at the same moment. A host starts a request with a start address, a byte count and a direction. Data moves through a buffer port that is indexed from zero: write data is read from it, and read data is written into it.

The engine breaks a long request into chunks of at most 16 bytes, and the EEPROM address moves forward by the size of each chunk. A read chunk is one frame: the read opcode, the address high byte, the address low byte, then one dummy byte for each data byte. A write chunk has three parts. First a write-enable frame, then a frame with the write opcode, the address and the data, then status-read frames. The status reads repeat until the device reports that its internal write is finished, or until a bounded number of attempts has been used. The engine pauses for a set number of clock cycles between status reads. When the last chunk ends, or when polling gives up, the engine pulses a done strobe and presents a timeout flag next to it.

Top module: `eeprom_seq`

## Requirements
- R1: A write chunk is sent as a one-byte frame 0x06, then a separate frame 0x02, address high byte, address low byte, then the chunk's data bytes taken from the buffer in order. Chip select goes low between these frames.
- R2: A read chunk is a single frame: 0x03, address high byte, address low byte, then N dummy bytes of 0x00. The bytes received for the dummy positions are written to the buffer in order. Nothing from the first three positions is stored.
- R3: A request of L bytes is split into chunks of 16 bytes, with the remainder in the last chunk. Each chunk's address is the start address plus the bytes already sent, modulo 2^16. The buffer index continues from where the previous chunk stopped.
- R4: After each write frame the engine sends status frames of 0x05, 0x00. Bit 0 of the second received byte set to 1 means busy, and the engine polls again. Bit 0 cleared to 0 ends polling for that chunk.
- R5: Between two consecutive status frames, chip select stays low for at least POLL_GAP clock cycles.
- R6: After MAX_POLLS status frames that all report busy, the engine sends no more frames. It pulses `done` with `timeout` at 1.
- R7: `done` is high for exactly one cycle after the final chunk, and `busy` is low the cycle after. `timeout` is 0 for a request that completes, and holds its value until the next accepted request.
- R8: A request with a length of 0 sends no frame and raises `done` within two cycles of the request.
- R9: A `reqStart` pulse while `busy` is high is ignored, and the running request's byte stream does not change.
- R10: `spiReq` is high only while `spiCs` is high. Once raised, `spiReq` and `spiTx` hold steady until the cycle in which `spiAck` is high.
- R11: After reset, `busy`, `done`, `timeout`, `spiCs`, `spiReq` and `bufWrEn` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqStart | input | 1 | One-cycle pulse that starts a request when idle |
| reqWrite | input | 1 | 1 selects a write request, 0 a read request |
| reqAddr | input | 16 | Start address in the EEPROM |
| reqLen | input | LEN_W | Number of data bytes |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle end-of-request strobe |
| timeout | output | 1 | Status polling gave up (valid with done) |
| spiCs | output | 1 | Chip select level, high = device selected |
| spiReq | output | 1 | Byte transfer request to the SPI master |
| spiTx | output | 8 | Byte to shift out |
| spiAck | input | 1 | Byte transfer finished, spiRx valid |
| spiRx | input | 8 | Byte shifted in |
| bufIdx | output | LEN_W | Buffer index for the current data byte |
| bufRdData | input | 8 | Write data at bufIdx |
| bufWrEn | output | 1 | Store bufWrData at bufIdx |
| bufWrData | output | 8 | Read data to store |

## Verification
A wrong chunk counter or address register shows up on the SPI port as soon as the next frame header goes out. The bench compares every byte, and every frame start, against a stream that it derives from the request. A faulty poll counter or pause counter either changes the number of status frames or shortens the chip-select low time before the next status frame, and the bench catches this within one poll interval. A data-index fault lands in the wrong buffer slot or memory cell, which the contents check at the end of each request exposes.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] FILLER   = 8'h00;

  typedef enum logic [2:0] {
    TX_WREN, TX_RDSR, TX_READ, TX_WRITE,
    TX_ADDR_HI, TX_ADDR_LO, TX_DATA, TX_DUMMY
  } txSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   loadReq;
    logic   nextChunk;
    logic   incIdx;
    logic   clrPoll;
    logic   capStat;
    logic   loadGap;
    logic   decGap;
    logic   bufWr;
    txSel_e txSel;
  } dpCtl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic reqZero;
    logic isWrite;
    logic lastData;
    logic lastChunk;
    logic pollMax;
    logic gapZero;
    logic devBusy;
  } dpSts_t;

endpackage

// File: rtl/eeprom_seq_dp.sv
module eeprom_seq_dp
  import eeprom_seq_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int CHUNK     = 16,
  parameter int MAX_POLLS = 1000,
  parameter int POLL_GAP  = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [15:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             reqWrite,
  input  logic             statIn,
  input  logic [7:0]       bufRdData,
  output logic [7:0]       txByte,
  output logic [LEN_W-1:0] bufIdx,
  output dpSts_t           sts
);

  localparam int CHUNK_W = $clog2(CHUNK + 1);
  localparam int POLL_W  = $clog2(MAX_POLLS + 1);
  localparam int GAP_W   = $clog2(POLL_GAP + 1);

  logic [15:0]        curAddr;
  logic [LEN_W-1:0]   remain;
  logic [LEN_W-1:0]   base;
  logic [CHUNK_W-1:0] byteIdx;
  logic [CHUNK_W-1:0] chunkLen;
  logic [POLL_W-1:0]  pollCnt;
  logic [GAP_W-1:0]   gapCnt;
  logic               statBit;
  logic               isWrite;

  always_comb begin
    if (remain > LEN_W'(CHUNK)) chunkLen = CHUNK_W'(CHUNK);
    else                        chunkLen = remain[CHUNK_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      remain  <= '0;
      base    <= '0;
      byteIdx <= '0;
      isWrite <= 1'b0;
    end else if (ctl.loadReq) begin
      curAddr <= reqAddr;
      remain  <= reqLen;
      base    <= '0;
      byteIdx <= '0;
      isWrite <= reqWrite;
    end else if (ctl.nextChunk) begin
      curAddr <= curAddr + 16'(chunkLen);
      remain  <= remain - LEN_W'(chunkLen);
      base    <= base + LEN_W'(chunkLen);
      byteIdx <= '0;
    end else if (ctl.incIdx) begin
      byteIdx <= byteIdx + CHUNK_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollCnt <= '0;
      statBit <= 1'b0;
    end else if (ctl.clrPoll) begin
      pollCnt <= '0;
    end else if (ctl.capStat) begin
      pollCnt <= pollCnt + POLL_W'(1);
      statBit <= statIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            gapCnt <= '0;
    else if (ctl.loadGap) gapCnt <= GAP_W'(POLL_GAP);
    else if (ctl.decGap)  gapCnt <= gapCnt - GAP_W'(1);
  end

  always_comb begin
    unique case (ctl.txSel)
      TX_WREN:    txByte = OP_WREN;
      TX_RDSR:    txByte = OP_RDSR;
      TX_READ:    txByte = OP_READ;
      TX_WRITE:   txByte = OP_WRITE;
      TX_ADDR_HI: txByte = curAddr[15:8];
      TX_ADDR_LO: txByte = curAddr[7:0];
      TX_DATA:    txByte = bufRdData;
      default:    txByte = FILLER;
    endcase
  end

  assign bufIdx        = base + LEN_W'(byteIdx);
  assign sts.reqZero   = (reqLen == '0);
  assign sts.isWrite   = isWrite;
  assign sts.lastData  = (byteIdx == chunkLen - CHUNK_W'(1));
  assign sts.lastChunk = (remain <= LEN_W'(CHUNK));
  assign sts.pollMax   = (pollCnt == POLL_W'(MAX_POLLS));
  assign sts.gapZero   = (gapCnt == '0);
  assign sts.devBusy   = statBit;

  AST_IDX_IN_CHUNK: assert property (@(posedge clk) disable iff (!rstN)
    byteIdx <= chunkLen); // R3
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt <= POLL_W'(MAX_POLLS)); // R6
  AST_STORE_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    ctl.bufWr |-> !isWrite); // R2

endmodule

// File: rtl/eeprom_seq_ctrl.sv
module eeprom_seq_ctrl
  import eeprom_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqStart,
  input  logic   spiAck,
  input  dpSts_t sts,
  output dpCtl_t ctl,
  output logic   spiReq,
  output logic   spiCs,
  output logic   busy,
  output logic   done,
  output logic   timeout
);

  typedef enum logic [4:0] {
    S_IDLE, S_SETUP, S_WREN, S_WGAP, S_WR_OP, S_WR_AH, S_WR_AL, S_WR_DATA,
    S_PGAP, S_ST_OP, S_ST_DUM, S_ST_CHK, S_WAIT,
    S_RD_OP, S_RD_AH, S_RD_AL, S_RD_DATA, S_NEXT, S_DONE
  } state_e;

  state_e st, nxt;
  logic   timeoutQ;

  always_comb begin
    nxt       = st;
    ctl       = '0;
    ctl.txSel = TX_DUMMY;
    spiReq    = 1'b0;
    spiCs     = 1'b0;
    unique case (st)
      S_IDLE: if (reqStart) begin
        ctl.loadReq = 1'b1;
        nxt = sts.reqZero ? S_DONE : S_SETUP;
      end
      S_SETUP: nxt = sts.isWrite ? S_WREN : S_RD_OP;
      S_WREN: begin
        spiCs = 1'b1; spiReq = 1'b1; ctl.txSel = TX_WREN;
        if (spiAck) nxt = S_WGAP;
      end
      S_WGAP: nxt = S_WR_OP;
      S_WR_OP: begin
        spiCs = 1'b1; spiReq = 1'b1; ctl.txSel = TX_WRITE;
        if (spiAck) nxt = S_WR_AH;
      end
      S_WR_AH: begin
        spiCs = 1'b1; spiReq = 1'b1; ctl.txSel = TX_ADDR_HI;
        if (spiAck) nxt = S_WR_AL;
      end
      S_WR_AL: begin
        spiCs = 1'b1; spiReq = 1'b1; ctl.txSel = TX_ADDR_LO;
        if (spiAck) nxt = S_WR_DATA;
      end
      S_WR_DATA: begin
        spiCs = 1'b1; spiReq = 1'b1; ctl.txSel = TX_DATA;
        if (spiAck) begin
          ctl.incIdx = 1'b1;
          if (sts.lastData) begin
            ctl.clrPoll = 1'b1;
            nxt = S_PGAP;
          end
        end
      end
      S_PGAP: nxt = S_ST_OP;
      S_ST_OP: begin
        spiCs = 1'b1; spiReq = 1'b1; ctl.txSel = TX_RDSR;
        if (spiAck) nxt = S_ST_DUM;
      end
      S_ST_DUM: begin
        spiCs = 1'b1; spiReq = 1'b1; ctl.txSel = TX_DUMMY;
        if (spiAck) begin
          ctl.capStat = 1'b1;
          nxt = S_ST_CHK;
        end
      end
      S_ST_CHK: begin
        if (!sts.devBusy)    nxt = S_NEXT;
        else if (sts.pollMax) nxt = S_DONE;
        else begin
          ctl.loadGap = 1'b1;
          nxt = S_WAIT;
        end
      end
      S_WAIT: begin
        if (sts.gapZero) nxt = S_ST_OP;
        else             ctl.decGap = 1'b1;
      end
      S_RD_OP: begin
        spiCs = 1'b1; spiReq = 1'b1; ctl.txSel = TX_READ;
        if (spiAck) nxt = S_RD_AH;
      end
      S_RD_AH: begin
        spiCs = 1'b1; spiReq = 1'b1; ctl.txSel = TX_ADDR_HI;
        if (spiAck) nxt = S_RD_AL;
      end
      S_RD_AL: begin
        spiCs = 1'b1; spiReq = 1'b1; ctl.txSel = TX_ADDR_LO;
        if (spiAck) nxt = S_RD_DATA;
      end
      S_RD_DATA: begin
        spiCs = 1'b1; spiReq = 1'b1; ctl.txSel = TX_DUMMY;
        if (spiAck) begin
          ctl.bufWr  = 1'b1;
          ctl.incIdx = 1'b1;
          if (sts.lastData) nxt = S_NEXT;
        end
      end
      S_NEXT: begin
        ctl.nextChunk = 1'b1;
        nxt = sts.lastChunk ? S_DONE : S_SETUP;
      end
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                           timeoutQ <= 1'b0;
    else if (ctl.loadReq)                                timeoutQ <= 1'b0;
    else if (st == S_ST_CHK && sts.devBusy && sts.pollMax) timeoutQ <= 1'b1;
  end

  assign busy    = (st != S_IDLE);
  assign done    = (st == S_DONE);
  assign timeout = timeoutQ;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy); // R7
  AST_TMO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_IDLE && !reqStart) |=> $stable(timeoutQ)); // R7
  AST_GAP_BEFORE_POLL: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_WAIT && !sts.gapZero) |=> !spiCs); // R5

endmodule

// File: rtl/eeprom_seq.sv
module eeprom_seq
  import eeprom_seq_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int CHUNK     = 16,
  parameter int MAX_POLLS = 1000,
  parameter int POLL_GAP  = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqStart,
  input  logic             reqWrite,
  input  logic [15:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  output logic             busy,
  output logic             done,
  output logic             timeout,
  output logic             spiCs,
  output logic             spiReq,
  output logic [7:0]       spiTx,
  input  logic             spiAck,
  input  logic [7:0]       spiRx,
  output logic [LEN_W-1:0] bufIdx,
  input  logic [7:0]       bufRdData,
  output logic             bufWrEn,
  output logic [7:0]       bufWrData
);

  dpCtl_t ctl;
  dpSts_t sts;

  eeprom_seq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqStart(reqStart),
    .spiAck  (spiAck),
    .sts     (sts),
    .ctl     (ctl),
    .spiReq  (spiReq),
    .spiCs   (spiCs),
    .busy    (busy),
    .done    (done),
    .timeout (timeout)
  );

  eeprom_seq_dp #(
    .LEN_W    (LEN_W),
    .CHUNK    (CHUNK),
    .MAX_POLLS(MAX_POLLS),
    .POLL_GAP (POLL_GAP)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqAddr  (reqAddr),
    .reqLen   (reqLen),
    .reqWrite (reqWrite),
    .statIn   (spiRx[0]),
    .bufRdData(bufRdData),
    .txByte   (spiTx),
    .bufIdx   (bufIdx),
    .sts      (sts)
  );

  assign bufWrEn   = ctl.bufWr;
  assign bufWrData = spiRx;

  AST_REQ_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    spiReq |-> spiCs); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (spiReq && !spiAck) |=> spiReq && $stable(spiTx)); // R10

endmodule

// File: tb/eeprom_seq_bench.sv
module eeprom_seq_bench;

  localparam int LEN_W     = 16;
  localparam int CHUNK     = 16;
  localparam int MAX_POLLS = 6;
  localparam int POLL_GAP  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqStart = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic busy, done, timeout, spiCs, spiReq, bufWrEn;
  logic [7:0] spiTx, bufWrData, bufRdData;
  logic spiAck = 1'b0;
  logic [7:0] spiRx = '0;
  logic [LEN_W-1:0] bufIdx;

  always #5 clk = ~clk;

  logic [7:0] wrBuf [256];
  logic [7:0] rdBuf [256];
  logic [7:0] mem [int];
  int expQ[$];
  logic [7:0] pend[$];

  int total = 0, bad = 0;
  bit frameOpen = 0, wel = 0, stuck = 0;
  int fpos = 0, fop = 0, lastOp = -1, lowCnt = 0, busyLeft = 0, busyCfg = 0;
  int doneSeen = 0;
  bit tmoAtDone = 0;
  logic [15:0] faddr = '0;

  assign bufRdData = wrBuf[bufIdx[7:0]];

  eeprom_seq #(.LEN_W(LEN_W), .CHUNK(CHUNK), .MAX_POLLS(MAX_POLLS), .POLL_GAP(POLL_GAP))
  u_eeprom_seq (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqLen(reqLen), .busy(busy), .done(done), .timeout(timeout),
    .spiCs(spiCs), .spiReq(spiReq), .spiTx(spiTx), .spiAck(spiAck), .spiRx(spiRx),
    .bufIdx(bufIdx), .bufRdData(bufRdData), .bufWrEn(bufWrEn), .bufWrData(bufWrData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] memRd(input logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'hFF;
  endfunction

  function automatic logic [7:0] modelByte(input logic [7:0] tx);
    logic [7:0] r = 8'hFF;
    case (fop)
      6: wel = 1;
      5: if (fpos == 1) begin
           r = {7'b0, (stuck || busyLeft > 0)};
           if (busyLeft > 0) busyLeft--;
         end
      3: begin
           if (fpos == 1) faddr[15:8] = tx;
           else if (fpos == 2) faddr[7:0] = tx;
           else if (fpos >= 3) r = memRd(faddr + 16'(fpos - 3));
         end
      2: begin
           if (fpos == 1) faddr[15:8] = tx;
           else if (fpos == 2) faddr[7:0] = tx;
           else if (fpos >= 3) pend.push_back(tx);
         end
      default: ;
    endcase
    return r;
  endfunction

  task automatic closeFrame();
    if (fop == 2 && wel) begin
      foreach (pend[i]) mem[int'(faddr + 16'(i))] = pend[i];
      busyLeft = busyCfg;
      wel = 0;
    end
    pend.delete();
    lastOp = fop;
    frameOpen = 0;
    lowCnt = 0;
  endtask

  // SPI master + EEPROM model and stream comparison, sampled at negedge
  always @(negedge clk) begin
    if (rstN) begin
      if (done) begin doneSeen++; tmoAtDone = timeout; end
      if (spiReq && !spiCs) check(0, "R10 request outside frame", 0, 1);
      if (!spiCs) begin
        if (frameOpen) closeFrame();
        lowCnt++;
      end
      if (spiAck) spiAck = 1'b0;
      else if (spiReq) begin
        bit first;
        int got;
        first = !frameOpen;
        if (first) begin
          frameOpen = 1; fpos = 0; fop = int'(spiTx);
          if (fop == 5 && lastOp == 5)
            check(lowCnt >= POLL_GAP, "R5 low time between status frames", lowCnt, POLL_GAP);
          lowCnt = 0;
        end
        got = (first ? 256 : 0) + int'(spiTx);
        if (expQ.size() == 0) check(0, "R3 unexpected byte", got, -1);
        else begin
          int e;
          e = expQ.pop_front();
          check(got == e, "R1 R2 R4 byte and frame order", got, e);
        end
        spiRx = modelByte(spiTx);
        fpos++;
        spiAck = 1'b1;
      end
      #1;
      if (bufWrEn) rdBuf[bufIdx[7:0]] = bufWrData;
    end
  end

  task automatic buildExp(input logic [15:0] a0, input int n, input bit wr, input int polls, input bit stk);
    logic [15:0] a = a0;
    int rem = n, b = 0;
    while (rem > 0) begin
      int c;
      c = (rem > CHUNK) ? CHUNK : rem;
      if (wr) begin
        expQ.push_back(256 + 6);
        expQ.push_back(256 + 2); expQ.push_back(int'(a[15:8])); expQ.push_back(int'(a[7:0]));
        for (int i = 0; i < c; i++) expQ.push_back(int'(wrBuf[b + i]));
        if (stk) begin
          for (int k = 0; k < MAX_POLLS; k++) begin expQ.push_back(256 + 5); expQ.push_back(0); end
          break;
        end
        for (int k = 0; k <= polls; k++) begin expQ.push_back(256 + 5); expQ.push_back(0); end
      end else begin
        expQ.push_back(256 + 3); expQ.push_back(int'(a[15:8])); expQ.push_back(int'(a[7:0]));
        for (int i = 0; i < c; i++) expQ.push_back(0);
      end
      a = a + 16'(c); b += c; rem -= c;
    end
  endtask

  task automatic doReq(input logic [15:0] a, input int n, input bit wr, input int polls,
                       input bit stk, input bit glitch);
    int cyc = 0;
    busyCfg = polls; stuck = stk; doneSeen = 0;
    for (int i = 0; i < 256; i++) rdBuf[i] = 8'hEE;
    buildExp(a, n, wr, polls, stk);
    @(negedge clk);
    reqStart = 1'b1; reqWrite = wr; reqAddr = a; reqLen = LEN_W'(n);
    @(negedge clk);
    reqStart = 1'b0;
    cyc = 1;
    if (glitch) begin
      repeat (6) @(negedge clk);
      reqStart = 1'b1; reqWrite = !wr; reqAddr = 16'hBEEF; reqLen = LEN_W'(3);
      @(negedge clk);
      reqStart = 1'b0;
      cyc += 7;
    end
    while (doneSeen == 0 && cyc < 20000) begin @(negedge clk); cyc++; end
    if (n == 0) check(cyc <= 2, "R8 zero length completes quickly", cyc, 2);
    repeat (3) @(negedge clk);
    check(doneSeen == 1, "R7 single done pulse", doneSeen, 1);
    check(tmoAtDone == stk, "R6 R7 timeout flag at done", int'(tmoAtDone), int'(stk));
    check(timeout == stk, "R7 timeout held after done", int'(timeout), int'(stk));
    check(!busy, "R7 idle after done", int'(busy), 0);
    check(expQ.size() == 0, "R3 R6 R9 expected bytes left unsent", expQ.size(), 0);
    expQ.delete();
    if (!wr) for (int i = 0; i < n; i++)
      check(rdBuf[i] == memRd(a + 16'(i)), "R2 read data into buffer", int'(rdBuf[i]), int'(memRd(a + 16'(i))));
    if (wr && !stk) for (int i = 0; i < n; i++)
      check(memRd(a + 16'(i)) == wrBuf[i], "R1 data stored in device", int'(memRd(a + 16'(i))), int'(wrBuf[i]));
  endtask

  initial begin
    #1_500_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) wrBuf[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!busy && !done && !timeout, "R11 reset status outputs", int'({busy, done, timeout}), 0);
    check(!spiCs && !spiReq && !bufWrEn, "R11 reset SPI and buffer outputs", int'({spiCs, spiReq, bufWrEn}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    doReq(16'h1234, 5, 1, 2, 0, 0);   // R1 R4 R5 short write with polling
    doReq(16'h1234, 5, 0, 0, 0, 1);   // R2 R9 read back, ignored second request
    for (int i = 0; i < 256; i++) wrBuf[i] = 8'(i * 13 + 1);
    doReq(16'h00F8, 37, 1, 1, 0, 0);  // R3 chunks 16/16/5 across 0x0100
    doReq(16'h00F8, 37, 0, 0, 0, 0);  // R3 chunked read
    doReq(16'hFFF8, 16, 0, 0, 0, 0);  // R3 exactly one chunk at top of space
    doReq(16'h0100, 0, 1, 0, 0, 0);   // R8 zero length
    doReq(16'h0400, 20, 1, 0, 1, 0);  // R6 device never ready
    doReq(16'h0400, 4, 0, 0, 0, 0);   // R7 timeout cleared by next request
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule